// File: doc/BRIEF.md
# Legacy Interrupt Event Queue with Register Access

This block gathers the four legacy INTx wires (A to D) of a PCIe root port and turns every level change on them into a record in a small circular queue. Software finds out what happened by reading the record at the head of the queue and then discards that record by writing to the queue window. A cause register collects pending interrupt reasons and keeps them set until software clears them. A mask register selects which causes reach the single level-sensitive interrupt output.

Status words report whether the queue holds records, whether an event was lost because the queue was full, and whether the link is up. A read/write bridge-enable bit is also driven out as a pin. All access goes through a plain 32-bit register port. Writes take effect on the clock edge. Read data is combinational from the address and has no side effects.

Top module: `intx_queue_regs`

## Requirements
- R1: Register map (12-bit byte address): cause 0x138, mask 0x13C, PHY status 0x144, port status/control 0x148, queue word A 0x158, queue word B 0x15C. The mask register holds all 32 written bits and reads them back. Any other address reads 0 and ignores writes. After reset every register reads 0, except that PHY status follows its input.
- R2: `irq_out` is 1 exactly when the bitwise AND of the cause register and the mask register is nonzero. It follows a register write in the cycle after the write edge.
- R3: Cause bit 16 (INTx received) is set by every record accepted into the queue. Writing 1 to bit 16 clears it, but only while the queue is empty; while any record is queued, the bit stays 1. Cause bit 17 (MSI received) always reads 0. A write of 0 to a bit leaves that bit unchanged.
- R4: A change on an INTx input is registered at the first rising edge and written into the queue at the second rising edge. The record is readable after that second edge.
- R5: When several lines change in the same cycle, one record is queued per cycle, in ascending line order from 0 to 3.
- R6: Queue word A of a record is: bit 31 = 1 (valid), bit 30 = 0, bit 29 = new level (1 for assert, 0 for deassert), bits 28:27 = line number, bits 26:0 = 0. Queue word B always reads 0.
- R7: Reading either queue word does not remove the record. While the queue is empty, both words read 0.
- R8: A write of any value to queue word A or queue word B removes the head record. Such a write to an empty queue changes nothing.
- R9: The queue holds DEPTH-1 records (default 15). A record that arrives while the queue is full is dropped, and port status bit 19 is set. Bit 19 stays set until reset.
- R10: Port status bit 18 reads 1 while the queue holds at least one record and 0 otherwise.
- R11: Port status bit 0 is a read/write bridge-enable bit that drives `bridge_en`. The other bits written to that register have no effect.
- R12: PHY status bit 11 reads the current value of `link_up_in`. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| intx_in | input | 4 | Legacy interrupt lines A..D, synchronous to clk |
| link_up_in | input | 1 | Link-up indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_out | output | 1 | Level interrupt output |
| bridge_en | output | 1 | Bridge enable, from port status bit 0 |

## Verification
Register writes are seen on a read in the cycle after the write edge, and `irq_out` follows on that same cycle. An INTx change becomes visible only after the second rising edge. The bench checks the queue-not-empty bit once after the first edge, where it must still read 0, and again after the second edge, where it must read 1. All stimulus is driven on falling edges, and combinational read data is sampled shortly after a falling edge. Multi-line changes and overflow fills wait at least two cycles per expected record before the queue contents are read back.

// File: rtl/intq_pkg.sv
// Package: shared constants and the queued record type for the INTx queue.
// Assumes a 12-bit byte address and four legacy lines.
package intq_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int N_LINES = 4;
    localparam int LINE_W  = $clog2(N_LINES);

    localparam logic [ADDR_W-1:0] OFS_CAUSE = 12'h138;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h13C;
    localparam logic [ADDR_W-1:0] OFS_PHY   = 12'h144;
    localparam logic [ADDR_W-1:0] OFS_PORT  = 12'h148;
    localparam logic [ADDR_W-1:0] OFS_QWA   = 12'h158;
    localparam logic [ADDR_W-1:0] OFS_QWB   = 12'h15C;

    localparam int B_CAUSE_INTX = 16;
    localparam int B_CAUSE_MSI  = 17;
    localparam int B_LINK       = 11;
    localparam int B_BRIDGE     = 0;
    localparam int B_NEMPTY     = 18;
    localparam int B_OVF        = 19;
    localparam int B_REC_LINE   = 27;
    localparam int B_REC_LEVEL  = 29;
    localparam int B_REC_VALID  = 31;

    typedef struct packed {
        logic              level;
        logic [LINE_W-1:0] line;
    } intx_rec_t;
endpackage

// File: rtl/intx_change_scan.sv
// Module: samples the INTx lines and emits one change record per cycle.
// Assumes inputs are already synchronous to clk. Each cycle it reports the
// lowest-numbered line whose sampled level differs from the level last
// reported; that line's reported level is updated whether or not the queue
// accepts the record.
module intx_change_scan
    import intq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_in,
    output logic               push_req,
    output intx_rec_t          push_rec
);
    logic [N_LINES-1:0] sampled;
    logic [N_LINES-1:0] reported;
    logic [N_LINES-1:0] differs;
    logic [N_LINES-1:0] grant;

    // Register the raw line levels once.
    always_ff @(posedge clk) begin
        if (!rst_n) sampled <= '0;
        else        sampled <= lines_in;
    end

    assign differs = sampled ^ reported;

    // Lowest-index-first pick among changed lines.
    always_comb begin
        grant    = '0;
        push_req = 1'b0;
        push_rec = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (differs[i] && !push_req) begin
                grant[i]      = 1'b1;
                push_req      = 1'b1;
                push_rec.line = LINE_W'(i);
                push_rec.level = sampled[i];
            end
        end
    end

    // Track the last reported level per line.
    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_rep
            always_ff @(posedge clk) begin
                if (!rst_n)        reported[g] <= 1'b0;
                else if (grant[g]) reported[g] <= sampled[g];
            end
        end
    endgenerate
endmodule

// File: rtl/intx_ring.sv
// Module: circular record queue with one slot kept unused (DEPTH-1 usable).
// A push while full is dropped and sets a sticky overflow flag. A pop while
// empty is ignored. The fullness check uses the state before the edge.
module intx_ring
    import intq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  intx_rec_t                  push_rec,
    input  logic                       pop,
    output intx_rec_t                  head_rec,
    output logic                       empty,
    output logic                       push_ok,
    output logic                       ovf,
    output logic [$clog2(DEPTH)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);

    intx_rec_t        slots [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             full, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == PTR_W'(DEPTH-1));
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign head_rec = slots[rptr];

    // Store accepted records.
    always_ff @(posedge clk) begin
        if (push_ok) slots[wptr] <= push_rec;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky overflow on a dropped record.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovf <= 1'b0;
        else if (push && full) ovf <= 1'b1;
    end
endmodule

// File: rtl/intq_regs.sv
// Module: register file for cause, mask, PHY status, port status/control and
// the queue window. Read data is combinational and free of side effects;
// writes act on the clock edge. Assumes one access per cycle.
module intq_regs
    import intq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              link_up_in,
    input  logic              q_empty,
    input  logic              q_ovf,
    input  logic              q_push_ok,
    input  intx_rec_t         q_head,
    output logic              q_pop,
    output logic              cause_intx,
    output logic              bridge_en,
    output logic              irq_out
);
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] cause_word;
    logic [DATA_W-1:0] rec_word;
    logic              clr_intx;

    assign clr_intx = wr_en && (addr == OFS_CAUSE) && wdata[B_CAUSE_INTX];
    assign q_pop    = wr_en && ((addr == OFS_QWA) || (addr == OFS_QWB));

    // Sticky INTx cause: set on accepted record, held while queue non-empty.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_intx <= 1'b0;
        else        cause_intx <= (cause_intx && !clr_intx) || q_push_ok || !q_empty;
    end

    // Mask register, replaced whole on write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '0;
        else if (wr_en && addr == OFS_MASK) mask_q <= wdata;
    end

    // Bridge enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          bridge_en <= 1'b0;
        else if (wr_en && addr == OFS_PORT) bridge_en <= wdata[B_BRIDGE];
    end

    // Compose the cause word; the MSI cause is never raised here.
    always_comb begin
        cause_word = '0;
        cause_word[B_CAUSE_INTX] = cause_intx;
        cause_word[B_CAUSE_MSI]  = 1'b0;
    end

    // Compose queue word A from the head record.
    always_comb begin
        rec_word = '0;
        if (!q_empty) begin
            rec_word[B_REC_VALID] = 1'b1;
            rec_word[B_REC_LEVEL] = q_head.level;
            rec_word[B_REC_LINE +: LINE_W] = q_head.line;
        end
    end

    // Level interrupt from masked causes.
    assign irq_out = |(cause_word & mask_q);

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CAUSE: rdata = cause_word;
            OFS_MASK:  rdata = mask_q;
            OFS_PHY:   rdata[B_LINK] = link_up_in;
            OFS_PORT: begin
                rdata[B_BRIDGE] = bridge_en;
                rdata[B_NEMPTY] = !q_empty;
                rdata[B_OVF]    = q_ovf;
            end
            OFS_QWA:   rdata = rec_word;
            OFS_QWB:   rdata = '0;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/intx_queue_regs.sv
// Module: top of the legacy interrupt event queue. Connects the line change
// scanner, the record ring and the register file. Assumes synchronous inputs.
module intx_queue_regs
    import intq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  intx_in,
    input  logic        link_up_in,
    input  logic        wr_en,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq_out,
    output logic        bridge_en
);
    localparam int CNT_W = $clog2(DEPTH);

    logic             push_req;
    intx_rec_t        push_rec;
    intx_rec_t        head_rec;
    logic             q_empty, q_push_ok, q_ovf, q_pop;
    logic [CNT_W-1:0] q_count;
    logic             cause_intx;

    intx_change_scan u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (intx_in),
        .push_req (push_req),
        .push_rec (push_rec)
    );

    intx_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_req),
        .push_rec (push_rec),
        .pop      (q_pop),
        .head_rec (head_rec),
        .empty    (q_empty),
        .push_ok  (q_push_ok),
        .ovf      (q_ovf),
        .count    (q_count)
    );

    intq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .link_up_in (link_up_in),
        .q_empty    (q_empty),
        .q_ovf      (q_ovf),
        .q_push_ok  (q_push_ok),
        .q_head     (head_rec),
        .q_pop      (q_pop),
        .cause_intx (cause_intx),
        .bridge_en  (bridge_en),
        .irq_out    (irq_out)
    );
endmodule

// File: rtl/intx_queue_regs_chk.sv
// Checker: temporal properties of the INTx queue, bound into the top.
module intx_queue_regs_chk #(
    parameter int DEPTH = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [11:0]              addr,
    input logic                     push_req,
    input logic                     q_ovf,
    input logic [$clog2(DEPTH)-1:0] q_count,
    input logic                     cause_intx,
    input logic                     bridge_en
);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovf |=> q_ovf);

    // R9
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && q_count == ($clog2(DEPTH))'(DEPTH-1)) |=> q_ovf);

    // R3
    intx_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count != '0) |-> cause_intx);

    // R8
    empty_pop_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 12'h158 || addr == 12'h15C) && q_count == '0 && !push_req)
        |=> (q_count == '0));

    // R11
    bridge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 12'h148) |=> $stable(bridge_en));
endmodule

bind intx_queue_regs intx_queue_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .push_req   (push_req),
    .q_ovf      (q_ovf),
    .q_count    (q_count),
    .cause_intx (cause_intx),
    .bridge_en  (bridge_en)
);

// File: tb/intx_queue_regs_test.sv
module intx_queue_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  intx_in = '0;
    logic        link_up_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out, bridge_en;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    localparam logic [11:0] A_CAUSE = 12'h138, A_MASK = 12'h13C, A_PHY = 12'h144,
                            A_PORT = 12'h148, A_QWA = 12'h158, A_QWB = 12'h15C;

    intx_queue_regs uut (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] rec(input int line, input bit lvl);
        return 32'h8000_0000 | (32'(lvl) << 29) | (32'(line) << 27);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); peek(a, v);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset values, mask read/write, unmapped addresses, PHY status.
    task automatic t_reset_regs();
        logic [31:0] v;
        rd(A_CAUSE, v); chk("R1 cause reset", v, 0);
        rd(A_MASK, v);  chk("R1 mask reset", v, 0);
        rd(A_PORT, v);  chk("R1 port reset", v, 0);
        rd(A_QWA, v);   chk("R7 qwA empty", v, 0);
        rd(A_QWB, v);   chk("R7 qwB empty", v, 0);
        rd(A_PHY, v);   chk("R12 link down", v, 0);
        chk("R2 irq reset", 32'(irq_out), 0);
        link_up_in = 1'b1;
        rd(A_PHY, v);   chk("R12 link up", v, 32'h0000_0800);
        wr(A_MASK, 32'hDEAD_BEEF);
        rd(A_MASK, v);  chk("R1 mask readback", v, 32'hDEAD_BEEF);
        chk("R2 irq no cause", 32'(irq_out), 0);
        wr(A_MASK, 32'h0);
        wr(12'h200, 32'hFFFF_FFFF);
        rd(12'h200, v); chk("R1 unmapped", v, 0);
    endtask

    // Single event: timing, format, peek, W1C hold, pop, empty pop.
    task automatic t_single();
        logic [31:0] v;
        @(negedge clk); intx_in = 4'b0100;
        @(negedge clk); peek(A_PORT, v); chk("R4 not yet queued", v & 32'h0004_0000, 0);
        @(negedge clk); peek(A_PORT, v); chk("R10 nonempty", v & 32'h0004_0000, 32'h0004_0000);
        peek(A_QWA, v); chk("R6 word A", v, rec(2, 1));
        rd(A_QWB, v);   chk("R6 word B zero", v, 0);
        rd(A_QWA, v);   chk("R7 read non-destructive", v, rec(2, 1));
        rd(A_CAUSE, v); chk("R3 cause set", v, 32'h0001_0000);
        chk("R2 irq masked off", 32'(irq_out), 0);
        wr(A_MASK, 32'h0001_0000);
        chk("R2 irq on", 32'(irq_out), 1);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rd(A_CAUSE, v); chk("R3 held while queued", v, 32'h0001_0000);
        wr(A_QWB, 32'h0);
        rd(A_PORT, v);  chk("R8 pop via word B", v & 32'h0004_0000, 0);
        rd(A_QWA, v);   chk("R7 empty after pop", v, 0);
        rd(A_CAUSE, v); chk("R3 sticky after drain", v, 32'h0001_0000);
        wr(A_CAUSE, 32'h0000_0000);
        rd(A_CAUSE, v); chk("R3 zero write keeps", v, 32'h0001_0000);
        wr(A_CAUSE, 32'h0001_0000);
        rd(A_CAUSE, v); chk("R3 W1C when empty", v, 0);
        chk("R2 irq off", 32'(irq_out), 0);
        wr(A_QWA, 32'h1234);
        rd(A_PORT, v);  chk("R8 empty pop no effect", v & 32'h0004_0000, 0);
        wr(A_MASK, 32'h0);
    endtask

    // Four simultaneous changes queued in ascending line order.
    task automatic t_multi();
        logic [31:0] v;
        logic [31:0] exp [4];
        exp[0] = rec(0, 1); exp[1] = rec(1, 1); exp[2] = rec(2, 0); exp[3] = rec(3, 1);
        @(negedge clk); intx_in = 4'b1011;
        settle(7);
        for (int i = 0; i < 4; i++) begin
            rd(A_QWA, v); chk("R5 order", v, exp[i]);
            wr(A_QWA, 32'h0);
        end
        rd(A_PORT, v); chk("R10 drained", v & 32'h0004_0000, 0);
        wr(A_CAUSE, 32'h0001_0000);
    endtask

    // Fill to capacity, overflow drop, sticky flag.
    task automatic t_overflow();
        logic [31:0] v;
        bit lvl = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); lvl = ~lvl; intx_in[0] = lvl;
            settle(3);
            if (i == 14) begin
                peek(A_PORT, v); chk("R9 full no ovf", v & 32'h000C_0000, 32'h0004_0000);
            end
        end
        rd(A_PORT, v); chk("R9 ovf set", v & 32'h000C_0000, 32'h000C_0000);
        lvl = 1'b1;
        for (int i = 0; i < 15; i++) begin
            lvl = ~lvl;
            rd(A_QWA, v); chk("R9 kept record", v, rec(0, lvl));
            wr(A_QWA, 32'h0);
        end
        rd(A_PORT, v); chk("R9 ovf sticky", v & 32'h000C_0000, 32'h0008_0000);
        @(negedge clk); intx_in[0] = 1'b0;
        settle(3);
        rd(A_QWA, v); chk("R9 after overflow", v, rec(0, 0));
        wr(A_QWB, 32'h0);
        rd(A_PORT, v); chk("R9 ovf still set", v & 32'h000C_0000, 32'h0008_0000);
    endtask

    // Bridge enable bit.
    task automatic t_bridge();
        logic [31:0] v;
        wr(A_PORT, 32'hFFFF_FFFF);
        chk("R11 bridge_en on", 32'(bridge_en), 1);
        rd(A_PORT, v); chk("R11 only bit0 writable", v, 32'h0008_0001);
        wr(A_PORT, 32'h0);
        chk("R11 bridge_en off", 32'(bridge_en), 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        t_reset_regs();
        t_single();
        t_multi();
        t_overflow();
        t_bridge();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule